// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block holds the power-control byte of an 8051-class microcontroller and turns it into three clock enables. It drives one enable for the CPU clock, one for the clock shared by the timer, serial and interrupt logic, and one for the oscillator. The CPU writes the byte through the special-function-register bus. Setting the idle bit stops only the CPU clock. Setting the power-down bit stops the oscillator and so every clock. An enabled, pending interrupt ends idle without software help. Only a qualified reset ends power-down.

The raw reset input is not trusted until it has stayed high for a set number of input clock cycles. Only then is the internal reset raised. While the raw reset is high, the oscillator enable is forced on, so that the counting clock is running even when power-down had stopped it. The byte also carries a baud-doubling control for the serial port and two software flags. All three are exported as plain pins.

All pins are plain control and status signals. No part of this block carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A write with `sfr_we_i` high and `sfr_addr_i` equal to 8'h87 updates the control byte on that clock edge. Writes to any other address leave it unchanged. `sfr_rdata_o` shows the byte while the address is 8'h87 and shows 8'h00 otherwise.
- R2: Bits 6 to 4 of the control byte always read as zero, and writes to them have no effect.
- R3: Writing bit 0 = 1 and bit 1 = 0 enters idle on the edge that samples the write. After that edge, the CPU clock enable is low, while the peripheral and oscillator enables stay high.
- R4: Writing bit 1 = 1 enters power-down on the edge that samples the write. After that edge, the CPU, peripheral and oscillator enables are all low while the raw reset is low.
- R5: A write with bits 1 and 0 both set gives power-down. The byte then reads back with bit 1 = 1 and bit 0 = 0.
- R6: In idle, a high `irq_pend_i` at a clock edge clears bit 0 on that edge and restores the CPU clock enable. Bits 3 and 2 keep their values.
- R7: `irq_pend_i` has no effect while running or in power-down.
- R8: While idle or power-down is set, register writes are ignored, because the CPU is halted.
- R9: While `rst_req_i` is high, `osc_en_o` is high, with no clock edge needed.
- R10: `core_rst_o` goes high after the 24th consecutive clock edge with `rst_req_i` high. It stays high while the input stays high and drops at once when the input falls. A shorter pulse gives no reset.
- R11: On an edge with `core_rst_o` high, the byte clears to 8'h00. All three clock enables are then high.
- R12: `baud_dbl_o` follows bit 7 of the byte. `gflag_o[1]` follows bit 3 and `gflag_o[0]` follows bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_req_i | input | 1 | Raw reset request, active high |
| sfr_addr_i | input | 8 | SFR bus address |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | Control byte at its address, else zero |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Timer/serial/interrupt clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| baud_dbl_o | output | 1 | Serial baud doubling |
| gflag_o | output | 2 | Software flags |
| core_rst_o | output | 1 | Qualified reset |

## Verification
The checks take for granted that the bus does not write while the CPU clock enable is low, except for writes the bench sends on purpose to test R8. They also assume `irq_pend_i` and `rst_req_i` change only away from the rising edge. Checks that depend on the register stay quiet until a qualified reset has first been seen, since the byte is undefined before that. The bench changes every input on the falling edge and performs a full 24-cycle reset before any register traffic. It never lets the raw reset glitch within a cycle.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam int SFR_W    = 8;
  localparam int POS_IDL  = 0;
  localparam int POS_PD   = 1;
  localparam int POS_GFLO = 2;
  localparam int POS_GFHI = 3;
  localparam int POS_SMOD = 7;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;

  typedef struct packed {
    logic       smod;
    logic [1:0] gf;
    logic       pd;
    logic       idl;
  } pctl_t;

  function automatic logic [SFR_W-1:0] pctl_view(pctl_t c);
    logic [SFR_W-1:0] v;
    v = '0;
    v[POS_IDL]          = c.idl;
    v[POS_PD]           = c.pd;
    v[POS_GFHI:POS_GFLO] = c.gf;
    v[POS_SMOD]         = c.smod;
    return v;
  endfunction
endpackage

// File: rtl/pwr_rst_qual.sv
`timescale 1ns/1ps
module pwr_rst_qual #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_req_i,
  output logic core_rst_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CYCLES);

  logic [CW-1:0] run_q;

  // Consecutive-high counter; any low level restarts it at once.
  always_ff @(posedge clk_i or negedge rst_req_i) begin
    if (!rst_req_i)        run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign core_rst_o = rst_req_i && (run_q == LIMIT);
endmodule

// File: rtl/pwr_ctrl_reg.sv
`timescale 1ns/1ps
module pwr_ctrl_reg
  import pwr_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h87
) (
  input  logic              clk_i,
  input  logic              core_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [SFR_W-1:0]  wdata_i,
  input  logic              irq_pend_i,
  output pctl_t             ctl_o,
  output logic [SFR_W-1:0]  rdata_o
);
  pctl_t ctl_q, ctl_d;
  logic  hit, halted;

  assign hit    = we_i && (addr_i == SFR_ADDR);
  assign halted = ctl_q.idl || ctl_q.pd;

  always_comb begin
    ctl_d = ctl_q;
    if (hit && !halted) begin
      ctl_d.smod = wdata_i[POS_SMOD];
      ctl_d.gf   = wdata_i[POS_GFHI:POS_GFLO];
      ctl_d.pd   = wdata_i[POS_PD];
      // power-down wins: idle is not kept when both are written
      ctl_d.idl  = wdata_i[POS_IDL] && !wdata_i[POS_PD];
    end else if (ctl_q.idl && !ctl_q.pd && irq_pend_i) begin
      ctl_d.idl = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (core_rst_i) ctl_q <= '0;
    else            ctl_q <= ctl_d;
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = (addr_i == SFR_ADDR) ? pctl_view(ctl_q) : '0;
endmodule

// File: rtl/pwr_clk_gate.sv
`timescale 1ns/1ps
module pwr_clk_gate
  import pwr_pkg::*;
(
  input  pctl_t ctl_i,
  input  logic  rst_req_i,
  output logic  cpu_en_o,
  output logic  per_en_o,
  output logic  osc_en_o
);
  pmode_e mode;

  always_comb begin
    if (ctl_i.pd)       mode = MODE_PDOWN;
    else if (ctl_i.idl) mode = MODE_IDLE;
    else                mode = MODE_RUN;
  end

  always_comb begin
    cpu_en_o = 1'b1;
    per_en_o = 1'b1;
    osc_en_o = 1'b1;
    case (mode)
      MODE_IDLE:  cpu_en_o = 1'b0;
      MODE_PDOWN: begin
        cpu_en_o = 1'b0;
        per_en_o = 1'b0;
        osc_en_o = rst_req_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR   = 8'h87,
  parameter int              RST_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_req_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [SFR_W-1:0]  sfr_wdata_i,
  output logic [SFR_W-1:0]  sfr_rdata_o,
  input  logic              irq_pend_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              baud_dbl_o,
  output logic [1:0]        gflag_o,
  output logic              core_rst_o
);
  pctl_t ctl;

  pwr_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_qual (
    .clk_i(clk_i), .rst_req_i(rst_req_i), .core_rst_o(core_rst_o)
  );

  pwr_ctrl_reg #(.ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR)) u_reg (
    .clk_i(clk_i), .core_rst_i(core_rst_o), .addr_i(sfr_addr_i),
    .we_i(sfr_we_i), .wdata_i(sfr_wdata_i), .irq_pend_i(irq_pend_i),
    .ctl_o(ctl), .rdata_o(sfr_rdata_o)
  );

  pwr_clk_gate u_gate (
    .ctl_i(ctl), .rst_req_i(rst_req_i),
    .cpu_en_o(cpu_clk_en_o), .per_en_o(per_clk_en_o), .osc_en_o(osc_en_o)
  );

  assign baud_dbl_o = ctl.smod;
  assign gflag_o    = ctl.gf;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR   = 8'h87,
  parameter int              RST_CYCLES = 24
) (
  input logic              clk_i,
  input logic              rst_req_i,
  input logic [ADDR_W-1:0] sfr_addr_i,
  input logic              sfr_we_i,
  input logic [7:0]        sfr_wdata_i,
  input logic [7:0]        sfr_rdata_o,
  input logic              irq_pend_i,
  input logic              cpu_clk_en_o,
  input logic              per_clk_en_o,
  input logic              osc_en_o,
  input logic              baud_dbl_o,
  input logic [1:0]        gflag_o,
  input logic              core_rst_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic          armed = 1'b0;
  logic [CW-1:0] seen  = '0;
  logic          idle_now, pd_now;

  always_ff @(posedge clk_i) begin
    if (core_rst_o) armed <= 1'b1;
    if (!rst_req_i) seen <= '0;
    else if (seen != CW'(RST_CYCLES)) seen <= seen + 1'b1;
  end

  assign idle_now = !cpu_clk_en_o && per_clk_en_o;
  assign pd_now   = !per_clk_en_o;

  assert_rst_count_R10: assert property (@(posedge clk_i)
    rst_req_i |-> (core_rst_o == (seen == CW'(RST_CYCLES))));
  assert_rst_drop_R10: assert property (@(posedge clk_i)
    !rst_req_i |-> !core_rst_o);
  assert_rst_clears_R11: assert property (@(posedge clk_i)
    core_rst_o |=> (cpu_clk_en_o && per_clk_en_o && !baud_dbl_o && gflag_o == 2'b00));
  assert_osc_on_rst_R9: assert property (@(posedge clk_i)
    rst_req_i |-> osc_en_o);
  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!armed)
    sfr_rdata_o[6:4] == 3'b000);
  assert_idle_exit_R6: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
    (idle_now && irq_pend_i) |=> (cpu_clk_en_o && $stable(gflag_o)));
  assert_pd_holds_R7: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
    pd_now |=> pd_now);
  assert_pd_wins_R5: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
    (cpu_clk_en_o && sfr_we_i && sfr_addr_i == SFR_ADDR && sfr_wdata_i[1:0] == 2'b11)
      |=> (!per_clk_en_o && sfr_rdata_o[1:0] == 2'b10));
  assert_idle_keeps_per_R3: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
    per_clk_en_o |-> osc_en_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR), .RST_CYCLES(RST_CYCLES)
) u_chk (.*);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_req = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       irq = 1'b0;
  logic [7:0] rdata;
  logic       cpu_en, per_en, osc_en, baud, core_rst;
  logic [1:0] gflag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_req_i(rst_req), .sfr_addr_i(addr), .sfr_we_i(we),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .irq_pend_i(irq),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .baud_dbl_o(baud), .gflag_o(gflag), .core_rst_o(core_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {we, addr, wdata, irq, exp_cpu, exp_per, exp_osc, exp_rdata}
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h87, 8'h84, 1'b0, 1'b1, 1'b1, 1'b1, 8'h84}, // R1 R12 write smod+gf0
    {1'b1, 8'h88, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00}, // R1 other address
    {1'b0, 8'h87, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h84}, // R1 byte unchanged
    {1'b1, 8'h87, 8'h7C, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0C}, // R2 reserved dropped
    {1'b1, 8'h87, 8'h0D, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0D}, // R3 idle
    {1'b1, 8'h87, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0D}, // R8 write in idle
    {1'b0, 8'h87, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0C}, // R6 irq exit
    {1'b0, 8'h87, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0C}, // R7 irq in run
    {1'b1, 8'h87, 8'h83, 1'b0, 1'b0, 1'b0, 1'b0, 8'h82}, // R4 R5 pd wins
    {1'b0, 8'h87, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h82}, // R7 irq in pd
    {1'b1, 8'h87, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h82}  // R8 write in pd
  };

  task automatic reset_seq;
    @(negedge clk) rst_req = 1'b1;
    repeat (24) @(posedge clk);
    #1 chk(core_rst === 1'b1, "R10 qualified after 24", core_rst, 1);
    @(posedge clk);
    #1 chk(rdata === 8'h00, "R11 byte cleared", rdata, 0);
    chk({cpu_en, per_en, osc_en} === 3'b111, "R11 enables high", {cpu_en, per_en, osc_en}, 7);
    chk(baud === 1'b0 && gflag === 2'b00, "R11 R12 flags cleared", {baud, gflag}, 0);
    @(negedge clk) rst_req = 1'b0;
    #1 chk(core_rst === 1'b0, "R10 drops with input", core_rst, 0);
  endtask

  initial begin
    addr = 8'h87;
    repeat (2) @(posedge clk);
    reset_seq();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {we, addr, wdata, irq} = VEC[i][28:11];
      @(posedge clk);
      #1;
      chk(cpu_en === VEC[i][10], $sformatf("vec%0d R3 R4 R6 cpu_en", i), cpu_en, VEC[i][10]);
      chk(per_en === VEC[i][9],  $sformatf("vec%0d R3 R4 per_en", i), per_en, VEC[i][9]);
      chk(osc_en === VEC[i][8],  $sformatf("vec%0d R4 osc_en", i), osc_en, VEC[i][8]);
      chk(rdata === VEC[i][7:0], $sformatf("vec%0d R1 R2 R5 R8 rdata", i), rdata, VEC[i][7:0]);
      if (VEC[i][27:20] == 8'h87) begin
        chk(baud === VEC[i][7], $sformatf("vec%0d R12 baud", i), baud, VEC[i][7]);
        chk(gflag === VEC[i][3:2], $sformatf("vec%0d R12 R6 gflag", i), gflag, VEC[i][3:2]);
      end
    end

    @(negedge clk) {we, irq, addr} = {1'b0, 1'b0, 8'h87};
    // now in power-down: reset input must restart the oscillator at once
    @(negedge clk) rst_req = 1'b1;
    #1 chk(osc_en === 1'b1, "R9 osc forced by reset input", osc_en, 1);
    chk(per_en === 1'b0, "R4 peripherals still off", per_en, 0);
    repeat (23) @(posedge clk);
    #1 chk(core_rst === 1'b0, "R10 23 cycles not enough", core_rst, 0);
    @(negedge clk) rst_req = 1'b0;
    #1 chk(osc_en === 1'b0, "R4 R10 short pulse keeps pd", osc_en, 0);
    chk(rdata === 8'h82, "R10 short pulse keeps byte", rdata, 8'h82);
    @(posedge clk);
    #1 chk(core_rst === 1'b0, "R10 no reset after short pulse", core_rst, 0);
    reset_seq();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule